// File: doc/BRIEF.md
# SerDes Control-Register Access Engine

This block lets a client read or write one register in a SerDes lane register space without knowing how that space is reached. The lane registers sit behind a small memory-mapped window. To touch any lane register, a page-select word is first written to a fixed select register of the window. The target is then reached at a word offset inside the window. Lane registers are not reached one by one, though. Three control-register-interface registers (control, address, data) form a mailbox. The engine polls the mailbox busy flag, loads the address (and the data, for writes), and issues a start command. For reads it waits for busy to clear again and then fetches the data register.

A client offers a request on a valid/ready port. The request carries the direction, a 5-bit device id, a 16-bit lane address and 16-bit write data. A request is taken only while the engine is idle. The client may change its inputs in the cycle after acceptance; the engine keeps its own copy. The result comes back as a one-cycle response pulse with read data and an error flag. The response side has no back-pressure: the client must capture it in the cycle it appears. The window bus is a single-master port. Each beat lasts one cycle, and read data is returned in the same cycle as the beat.

Top module: `serdes_cr_access`

## Requirements
- R1: After reset, req_ready is 1, and bus_valid and rsp_valid are 0.
- R2: Every raw access is two beats in consecutive cycles. The first beat writes the window select offset 0x800. Its word has the device id in bits 11:7 and lane address bits 15:9 in bits 6:0, with the upper bits zero. The second beat reaches the target.
- R3: The target beat uses byte offset (lane address bits 8:0) times 4. The mailbox control, address and data registers are lane addresses 0x80a0, 0x80a1 and 0x80a2.
- R4: A read runs five raw accesses in order: poll control; write the lane address to the address register; write 0x0001 (start) to control; poll control; read the data register. The low 16 bits of that final read are returned on rsp_rdata.
- R5: A write runs four raw accesses in order: poll control; write the lane address to the address register; write the zero-extended data to the data register; write 0x0003 (start plus write direction) to control. No poll follows the last beat.
- R6: A poll reads control and treats bit 0 as busy. When busy is set, the bus stays idle for POLL_GAP cycles, and then the whole raw access (select and read) is repeated.
- R7: If a poll reads busy POLL_MAX times in a row, the request ends at once with rsp_error = 1 and rsp_rdata = 0, and no further beat is issued. Each poll phase starts a fresh count.
- R8: req_ready is 1 only while idle. It is 0 in every cycle that carries a bus beat, and a request is taken only on req_valid and req_ready.
- R9: rsp_valid is a single-cycle pulse in the cycle right after the final beat. For successful writes, rsp_error = 0 and rsp_rdata = 0.
- R10: The device id, address, data and direction are captured at acceptance. Input changes after that do not affect the beats of the running request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted on valid and ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Device id placed in the select word |
| req_addr | input | 16 | Lane register address |
| req_wdata | input | CR_DW | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_error | output | 1 | Busy poll timed out |
| rsp_rdata | output | CR_DW | Read data |
| bus_valid | output | 1 | Window bus beat present |
| bus_write | output | 1 | Beat is a write |
| bus_addr | output | 12 | Byte offset inside the window |
| bus_wdata | output | BUS_DW | Write data of the beat |
| bus_rdata | input | BUS_DW | Read data, valid in the same cycle as a read beat |

## Verification
The bench builds the engine with POLL_GAP = 3 and POLL_MAX = 4. With these values every busy count from zero up to and beyond the limit takes only a few dozen cycles. Each idle gap between polls is short enough to time exactly from the beat log. The bench sweeps all 32 device ids and a set of addresses around page boundaries. It also sweeps every pair of first-phase and second-phase busy counts from 0 to 4, so both ordinary completion and timeout in either poll phase are reached. A bench model of the window decodes the select word, counts busy reads and stores mailbox writes.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  // Window format (fixed by the addressing scheme)
  localparam int LANE_AW = 16;
  localparam int DEV_W   = 5;
  localparam int OFS_W   = 9;
  localparam int PAGE_W  = LANE_AW - OFS_W;
  localparam int SEL_W   = DEV_W + PAGE_W;
  localparam int BUS_AW  = OFS_W + 3;

  localparam logic [BUS_AW-1:0]  WIN_SEL_OFS = 12'h800;
  localparam logic [LANE_AW-1:0] MBX_CTL     = 16'h80a0;
  localparam logic [LANE_AW-1:0] MBX_ADR     = 16'h80a1;
  localparam logic [LANE_AW-1:0] MBX_DAT     = 16'h80a2;
  localparam logic [15:0]        CMD_GO      = 16'h0001;
  localparam logic [15:0]        CMD_GO_WR   = 16'h0003;

  typedef enum logic [1:0] {S_IDLE, S_PAGE, S_ACCESS, S_WAIT} seq_state_e;

  typedef enum logic [2:0] {
    OP_POLL, OP_SET_ADDR, OP_SET_DATA, OP_KICK_RD, OP_KICK_WR, OP_GET_DATA
  } mbx_op_e;

  // Step program of a request: reads take five steps, writes four
  function automatic mbx_op_e program_op(input logic is_wr, input logic [2:0] idx);
    mbx_op_e op;
    op = OP_POLL;
    if (is_wr) begin
      case (idx)
        3'd1:    op = OP_SET_ADDR;
        3'd2:    op = OP_SET_DATA;
        3'd3:    op = OP_KICK_WR;
        default: op = OP_POLL;
      endcase
    end else begin
      case (idx)
        3'd1:    op = OP_SET_ADDR;
        3'd2:    op = OP_KICK_RD;
        3'd4:    op = OP_GET_DATA;
        default: op = OP_POLL;
      endcase
    end
    return op;
  endfunction

  function automatic logic program_last(input logic is_wr, input logic [2:0] idx);
    return is_wr ? (idx == 3'd3) : (idx == 3'd4);
  endfunction

  function automatic logic [LANE_AW-1:0] op_target(input mbx_op_e op);
    logic [LANE_AW-1:0] t;
    case (op)
      OP_SET_ADDR:              t = MBX_ADR;
      OP_SET_DATA, OP_GET_DATA: t = MBX_DAT;
      default:                  t = MBX_CTL;
    endcase
    return t;
  endfunction

  function automatic logic op_writes(input mbx_op_e op);
    return !(op == OP_POLL || op == OP_GET_DATA);
  endfunction
endpackage

// File: rtl/pcr_window_map.sv
module pcr_window_map
  import pcr_pkg::*;
#(
  parameter int BUS_DW = 32
) (
  input  logic [DEV_W-1:0]   dev,
  input  logic [LANE_AW-1:0] lane_addr,
  output logic [BUS_DW-1:0]  page_word,
  output logic [BUS_AW-1:0]  tgt_ofs
);
  localparam int PAD_W = BUS_AW - OFS_W - 2;

  always_comb begin
    page_word            = '0;
    page_word[SEL_W-1:0] = {dev, lane_addr[LANE_AW-1:OFS_W]};
    tgt_ofs              = {{PAD_W{1'b0}}, lane_addr[OFS_W-1:0], 2'b00};
  end
endmodule

// File: rtl/pcr_gap_timer.sv
module pcr_gap_timer #(
  parameter int GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int CW = $clog2(GAP + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= CW'(GAP);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == CW'(1));

  // R6: the sequencer never restarts the gap while one is running
  p_gap_no_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> !load);
endmodule

// File: rtl/pcr_poll_guard.sv
module pcr_poll_guard #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic busy_hit,
  output logic last_try
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clear)     cnt <= '0;
    else if (busy_hit)  cnt <= cnt + 1'b1;
  end

  assign last_try = (cnt == CW'(LIMIT - 1));

  // R7: no busy reading is ever taken beyond the limit
  p_poll_within_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_hit |-> (cnt < CW'(LIMIT)));
endmodule

// File: rtl/serdes_cr_access.sv
module serdes_cr_access
  import pcr_pkg::*;
#(
  parameter int BUS_DW   = 32,
  parameter int CR_DW    = 16,
  parameter int POLL_GAP = 1250,
  parameter int POLL_MAX = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [DEV_W-1:0]    req_dev,
  input  logic [LANE_AW-1:0]  req_addr,
  input  logic [CR_DW-1:0]    req_wdata,
  output logic                rsp_valid,
  output logic                rsp_error,
  output logic [CR_DW-1:0]    rsp_rdata,
  output logic                bus_valid,
  output logic                bus_write,
  output logic [BUS_AW-1:0]   bus_addr,
  output logic [BUS_DW-1:0]   bus_wdata,
  input  logic [BUS_DW-1:0]   bus_rdata
);
  seq_state_e          state;
  logic                is_wr;
  logic [DEV_W-1:0]    dev_q;
  logic [LANE_AW-1:0]  addr_q;
  logic [CR_DW-1:0]    wdata_q;
  logic [2:0]          idx;
  logic                rsp_valid_q, rsp_err_q;
  logic [CR_DW-1:0]    rsp_rdata_q;

  mbx_op_e             cur_op;
  logic                op_last;
  logic [LANE_AW-1:0]  tgt_lane;
  logic [BUS_DW-1:0]   page_word;
  logic [BUS_AW-1:0]   tgt_ofs;
  logic [BUS_DW-1:0]   acc_data;
  logic                in_access, is_poll, busy_bit, busy_hit;
  logic                gap_load, gap_expire, guard_clear, last_try;
  logic                unused_rdata_hi;

  assign cur_op    = program_op(is_wr, idx);
  assign op_last   = program_last(is_wr, idx);
  assign tgt_lane  = op_target(cur_op);
  assign in_access = (state == S_ACCESS);
  assign is_poll   = (cur_op == OP_POLL);
  assign busy_bit  = bus_rdata[0];
  assign busy_hit  = in_access && is_poll && busy_bit;
  assign gap_load  = busy_hit && !last_try;
  assign guard_clear = (state == S_IDLE) || (in_access && !busy_hit);
  assign unused_rdata_hi = ^bus_rdata[BUS_DW-1:CR_DW];

  pcr_window_map #(.BUS_DW(BUS_DW)) u_map (
    .dev       (dev_q),
    .lane_addr (tgt_lane),
    .page_word (page_word),
    .tgt_ofs   (tgt_ofs)
  );

  pcr_gap_timer #(.GAP(POLL_GAP)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (gap_load),
    .expire (gap_expire)
  );

  pcr_poll_guard #(.LIMIT(POLL_MAX)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (guard_clear),
    .busy_hit (busy_hit),
    .last_try (last_try)
  );

  // Data carried by the target beat of the current step
  always_comb begin
    case (cur_op)
      OP_SET_ADDR: acc_data = BUS_DW'(addr_q);
      OP_SET_DATA: acc_data = BUS_DW'(wdata_q);
      OP_KICK_RD:  acc_data = BUS_DW'(CMD_GO);
      OP_KICK_WR:  acc_data = BUS_DW'(CMD_GO_WR);
      default:     acc_data = '0;
    endcase
  end

  always_comb begin
    bus_valid = (state == S_PAGE) || in_access;
    bus_write = (state == S_PAGE) ? 1'b1 : op_writes(cur_op);
    bus_addr  = (state == S_PAGE) ? WIN_SEL_OFS : tgt_ofs;
    bus_wdata = (state == S_PAGE) ? page_word : (op_writes(cur_op) ? acc_data : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      is_wr       <= 1'b0;
      dev_q       <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      idx         <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            is_wr       <= req_write;
            dev_q       <= req_dev;
            addr_q      <= req_addr;
            wdata_q     <= req_wdata;
            idx         <= '0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
            state       <= S_PAGE;
          end
        end
        S_PAGE: state <= S_ACCESS;
        S_ACCESS: begin
          if (is_poll) begin
            if (!busy_bit) begin
              idx   <= idx + 3'd1;
              state <= S_PAGE;
            end else if (last_try) begin
              rsp_valid_q <= 1'b1;
              rsp_err_q   <= 1'b1;
              state       <= S_IDLE;
            end else begin
              state <= S_WAIT;
            end
          end else if (cur_op == OP_GET_DATA) begin
            rsp_rdata_q <= bus_rdata[CR_DW-1:0];
            rsp_valid_q <= 1'b1;
            state       <= S_IDLE;
          end else if (op_last) begin
            rsp_valid_q <= 1'b1;
            state       <= S_IDLE;
          end else begin
            idx   <= idx + 3'd1;
            state <= S_PAGE;
          end
        end
        S_WAIT:  if (gap_expire) state <= S_PAGE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_error = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;

  // R8: the request port is closed in every beat cycle
  p_ready_low_in_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready);

  // R2: a select beat is always followed at once by a target beat
  p_select_then_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr == WIN_SEL_OFS) |=> (bus_valid && bus_addr != WIN_SEL_OFS));

  // R2: a target beat always follows a select beat
  p_target_after_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr != WIN_SEL_OFS) |-> $past(bus_valid && bus_addr == WIN_SEL_OFS));

  // R9: response is a lone pulse right after a target beat
  p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_rsp_after_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_valid && bus_addr != WIN_SEL_OFS));

  // R7: an error only follows a read that saw busy
  p_error_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_error) |-> $past(bus_valid && !bus_write && bus_rdata[0]));
endmodule

// File: tb/serdes_cr_access_bench.sv
module serdes_cr_access_bench;
  localparam int GAP = 3;
  localparam int MAX = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_dev = '0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_error;
  logic [15:0] rsp_rdata;
  logic        bus_valid, bus_write;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #2 clk = ~clk;

  serdes_cr_access #(.BUS_DW(32), .CR_DW(16), .POLL_GAP(GAP), .POLL_MAX(MAX))
  u_serdes_cr_access (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] lane_val(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3c5a;
  endfunction
  function automatic logic [31:0] pw(input logic [4:0] d, input logic [15:0] a);
    return {20'b0, d, a[15:9]};
  endfunction
  function automatic logic [11:0] ofs(input logic [15:0] a);
    return {1'b0, a[8:0], 2'b00};
  endfunction

  // ---------------- window model ----------------
  logic [11:0] page_q = '0;
  logic [15:0] m_addr = '0, m_data = '0, last_wa = '0, last_wd = '0;
  int          busy_left = 0, busy_first = 0, busy_second = 0;
  int          cyc = 0, rsp_cyc = 0, l_n = 0;
  logic        l_wr[64];
  logic [11:0] l_addr[64];
  logic [31:0] l_data[64];
  int          l_cyc[64];
  logic [15:0] lane;

  assign lane = {page_q[6:0], bus_addr[10:2]};
  always_comb begin
    bus_rdata = 32'hdead_0000;
    if (bus_valid && !bus_write && bus_addr != 12'h800) begin
      if (lane == 16'h80a0)      bus_rdata = {31'b0, busy_left != 0};
      else if (lane == 16'h80a2) bus_rdata = {16'h0, m_data};
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rsp_valid) rsp_cyc <= cyc;
    if (req_valid && req_ready) begin
      l_n <= 0;
      busy_left <= busy_first;
      last_wa <= 16'hbeef;
      last_wd <= 16'hbeef;
    end else if (bus_valid) begin
      if (l_n < 64) begin
        l_wr[l_n] <= bus_write; l_addr[l_n] <= bus_addr;
        l_data[l_n] <= bus_wdata; l_cyc[l_n] <= cyc;
      end
      l_n <= l_n + 1;
      if (bus_write && bus_addr == 12'h800) page_q <= bus_wdata[11:0];
      else if (bus_write) begin
        if (lane == 16'h80a1) m_addr <= bus_wdata[15:0];
        if (lane == 16'h80a2) m_data <= bus_wdata[15:0];
        if (lane == 16'h80a0 && bus_wdata[0]) begin
          busy_left <= busy_second;
          if (bus_wdata[1]) begin last_wa <= m_addr; last_wd <= m_data; end
          else m_data <= lane_val(m_addr);
        end
      end else if (lane == 16'h80a0 && busy_left > 0) busy_left <= busy_left - 1;
    end
  end

  bit ready_bad = 0;
  always @(negedge clk) if (bus_valid && req_ready) ready_bad = 1;

  // ---------------- expected beat list ----------------
  logic        e_wr[64];
  logic [11:0] e_addr[64];
  logic [31:0] e_data[64];
  int          e_gap[64];
  int          e_n;

  task automatic push(input logic wr, input logic [11:0] a, input logic [31:0] d, input int gap);
    e_wr[e_n] = wr; e_addr[e_n] = a; e_data[e_n] = d; e_gap[e_n] = gap; e_n++;
  endtask

  task automatic raw(input logic [4:0] dev, input logic wr, input logic [15:0] la,
                     input logic [31:0] d, input int gap);
    push(1'b1, 12'h800, pw(dev, la), gap);
    push(wr, ofs(la), d, 1);
  endtask

  task automatic exp_poll(input logic [4:0] dev, input int b, input bit first, output bit to);
    int reads;
    reads = (b >= MAX) ? MAX : b + 1;
    for (int i = 0; i < reads; i++)
      raw(dev, 1'b0, 16'h80a0, 0, (i == 0) ? (first ? 0 : 1) : GAP + 1);
    to = (b >= MAX);
  endtask

  task automatic do_req(input bit wr, input logic [4:0] dev, input logic [15:0] a,
                        input logic [15:0] wd, input int b1, input int b2);
    bit to;
    bit exp_err;
    logic [15:0] exp_rd, got_rd;
    logic got_err;
    string rq;
    e_n = 0;
    exp_poll(dev, b1, 1'b1, to);
    if (!to) begin
      raw(dev, 1'b1, 16'h80a1, {16'h0, a}, 1);
      if (wr) begin
        raw(dev, 1'b1, 16'h80a2, {16'h0, wd}, 1);
        raw(dev, 1'b1, 16'h80a0, 32'h3, 1);
      end else begin
        raw(dev, 1'b1, 16'h80a0, 32'h1, 1);
        exp_poll(dev, b2, 1'b0, to);
        if (!to) raw(dev, 1'b0, 16'h80a2, 0, 1);
      end
    end
    exp_err = to;
    exp_rd  = (!wr && !to) ? lane_val(a) : 16'h0;
    busy_first = b1; busy_second = b2;
    ready_bad = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_dev = dev; req_addr = a; req_wdata = wd;
    @(posedge clk); #1;
    // R10: scramble inputs right after acceptance
    req_valid = 0; req_write = ~wr; req_dev = ~dev; req_addr = ~a; req_wdata = ~wd;
    do @(negedge clk); while (!rsp_valid);
    got_err = rsp_error; got_rd = rsp_rdata;
    chk(req_ready === 1'b1, "R8 ready back with response", {31'b0, req_ready}, 1);
    @(posedge clk); #1;
    chk(!ready_bad, "R8 ready low during beats", {31'b0, ready_bad}, 0);
    rq = wr ? "R5 beat count" : "R4 beat count";
    chk(l_n == e_n, rq, l_n, e_n);
    if (l_n == e_n) begin
      for (int i = 0; i < e_n; i++) begin
        rq = (e_addr[i] == 12'h800) ? "R2 select beat R10" : "R3 target beat R10";
        chk(l_wr[i] === e_wr[i] && l_addr[i] === e_addr[i] &&
            (!e_wr[i] || l_data[i] === e_data[i]), rq,
            {l_wr[i], 7'b0, l_addr[i], l_data[i][11:0]},
            {e_wr[i], 7'b0, e_addr[i], e_data[i][11:0]});
        if (i > 0 && e_gap[i] > 0)
          chk(l_cyc[i] - l_cyc[i-1] == e_gap[i], "R6 beat spacing",
              l_cyc[i] - l_cyc[i-1], e_gap[i]);
      end
      if (e_n > 0)
        chk(rsp_cyc == l_cyc[e_n-1] + 1, "R9 response timing", rsp_cyc, l_cyc[e_n-1] + 1);
    end
    chk(got_err === exp_err, "R7 error flag", {31'b0, got_err}, {31'b0, exp_err});
    chk(got_rd === exp_rd, wr ? "R9 write rdata" : "R4 read data", {16'h0, got_rd}, {16'h0, exp_rd});
    if (wr && !exp_err)
      chk(last_wa === a && last_wd === wd, "R5 mailbox write R10",
          {last_wa, last_wd}, {a, wd});
  endtask

  logic [15:0] addrs[6] = '{16'h0000, 16'h01ff, 16'h0200, 16'h80a3, 16'hffff, 16'h1234};

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1 && bus_valid === 1'b0 && rsp_valid === 1'b0, "R1 reset state",
        {29'b0, req_ready, bus_valid, rsp_valid}, 32'h4);
    // all device ids, read and write, no busy
    for (int d = 0; d < 32; d++) begin
      do_req(1'b0, 5'(d), addrs[d % 6], 16'h0, 0, 0);
      do_req(1'b1, 5'(d), addrs[(d + 3) % 6], 16'(d * 16'h0911 + 7), 0, 0);
    end
    // busy sweep, both poll phases, including timeout (R6, R7)
    for (int b1 = 0; b1 <= MAX; b1++) begin
      for (int b2 = 0; b2 <= MAX; b2++)
        do_req(1'b0, 5'(b1 * 5 + b2), addrs[(b1 + b2) % 6], 16'h0, b1, b2);
      do_req(1'b1, 5'(31 - b1), addrs[b1 % 6], 16'ha5a5 ^ 16'(b1), b1, 0);
    end
    // a clean read after a timeout
    do_req(1'b0, 5'h1f, 16'hffff, 16'h0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog expired got %0d exp %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule